// File: doc/BRIEF.md
# Periodic Interrupt Timer with Strap-Selected Prescaler

This block raises an interrupt request at a fixed programmable interval. The interval is derived from a reference tick: a one-cycle enable pulse on the system clock. The reference tick first passes through a fixed divide-by-4 stage. An optional divide-by-512 prescaler follows, and then an 8-bit down-counter that reloads from a programmed modulus. Each time the down-counter expires, a sticky request flag is set. The flag stays set until the interrupt handler acknowledges it.

Software reaches the block through a small register port with two locations. One location holds the modulus. The other holds the prescaler select bit. The reset value of the prescaler select is not fixed: while reset is held, the block captures the inverse of a mode strap input. A modulus of zero parks the timer. Any register write restarts the current period from its beginning.

Top module: `periodic_irq_timer`

## Requirements
- R1: While reset is held and directly after it is released, the modulus reads 0 and `irq_req` is low.
- R2: While `rst_n` is low, the prescaler select bit takes the inverse of `strap_in`. The value present in the last reset cycle is kept after release. Later changes on `strap_in` have no effect.
- R3: The register map is as follows. Address 0 holds the 8-bit modulus. Address 1 holds the prescaler select in bit 0, and its other bits read as 0. Register writes take effect on the clock edge where `wr_en` is high. `rd_data` shows the register selected by `rd_addr` combinationally.
- R4: With the prescaler select at 0 and a modulus M from 1 to 255, `irq_req` goes high right after the clock edge that consumes the 4·M-th reference tick counted after the last register write. Cycles in which `ref_tick` is low do not advance the timer.
- R5: With the prescaler select at 1, the period is 2048·M reference ticks.
- R6: While the modulus is 0, no interrupt request is raised, however many ticks arrive.
- R7: After an expiry, the counter reloads by itself. The next expiry follows after one further full period, with no rewrite needed.
- R8: `irq_req` stays high until `irq_ack` is sampled high. It is low after that edge, unless a new expiry occurs in the same cycle.
- R9: An expiry in the same cycle as `irq_ack` takes priority, and `irq_req` stays high.
- R10: A write to either register clears the divide stages and reloads the counter. The next expiry therefore comes one full period after the write. Reference ticks in the write cycle are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference clock enable |
| strap_in | input | 1 | Mode strap; its inverse becomes the prescaler select during reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 modulus, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 modulus, 1 control |
| rd_data | output | 8 | Combinational read data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the request |
| irq_req | output | 1 | Sticky interrupt request |

## Verification
The request is registered. It is due right after the clock edge that consumes the 4·M-th reference tick, or the 2048·M-th tick, counted after the edge that accepted the last write. The bench counts those ticks itself as it drives them. It checks one tick early that `irq_req` is still low and one tick later that it is high, always sampling at the falling edge. Clearing by acknowledge, and the priority of an expiry in the acknowledge cycle, are due one edge after the acknowledge. Register reads are combinational and are sampled in the cycle after the write edge.

// File: rtl/pit_pkg.sv
// Package: shared register address encoding and fixed divider ratios for
// the periodic interrupt timer. Assumes a two-entry register space.
package pit_pkg;
    typedef enum logic [0:0] {
        PIT_ADDR_MOD = 1'b0,
        PIT_ADDR_CTL = 1'b1
    } pit_addr_e;

    localparam int PIT_FRONT_DIV = 4;
    localparam int PIT_PRESCALE  = 512;
endpackage

// File: rtl/pit_tick_div.sv
// Module: divides a one-cycle enable pulse by DIV. The output pulse is issued
// combinationally in the cycle of the DIV-th input pulse. Assumes clr has
// priority over counting, so a cleared divider restarts a full ratio.
module pit_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_tick,
    output logic out_tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign out_tick = in_tick;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;
            logic          at_last;

            assign at_last  = (cnt_q == LAST);
            assign out_tick = in_tick && at_last && !clr;

            // Counts input pulses modulo DIV, restarting on clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        cnt_q <= '0;
                else if (clr)      cnt_q <= '0;
                else if (in_tick)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pit_regs.sv
// Module: register file for the timer. It holds the modulus and the
// prescaler select, captures the inverted strap during reset, flags writes
// and provides a combinational read mux. Assumes a single write port.
module pit_regs
    import pit_pkg::*;
#(
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [MOD_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [MOD_W-1:0] rd_data,
    output logic [MOD_W-1:0] mod_q,
    output logic             pre_sel_q,
    output logic             mod_wr,
    output logic             ctl_wr
);
    pit_addr_e wa, ra;

    assign wa     = pit_addr_e'(wr_addr);
    assign ra     = pit_addr_e'(rd_addr);
    assign mod_wr = wr_en && (wa == PIT_ADDR_MOD);
    assign ctl_wr = wr_en && (wa == PIT_ADDR_CTL);

    // Modulus register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (mod_wr) mod_q <= wr_data;
    end

    // Prescaler select; tracks the inverted strap while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_sel_q <= ~strap_in;
        else if (ctl_wr) pre_sel_q <= wr_data[0];
    end

    // Read mux for the two locations.
    always_comb begin
        rd_data = '0;
        case (ra)
            PIT_ADDR_MOD: rd_data = mod_q;
            PIT_ADDR_CTL: rd_data[0] = pre_sel_q;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pit_down_counter.sv
// Module: modulus down-counter. A load takes load_val. Each tick decrements;
// a tick at count 1 reloads from mod_val and pulses expire. Assumes a zero
// modulus keeps the count at zero, so it never expires.
module pit_down_counter #(
    parameter int MOD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [MOD_W-1:0] load_val,
    input  logic [MOD_W-1:0] mod_val,
    input  logic             tick,
    output logic             expire,
    output logic [MOD_W-1:0] count
);
    localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

    logic at_one;

    assign at_one = (count == ONE);
    assign expire = tick && !load && at_one;

    // Counter update: a load wins, otherwise count down and reload at one.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (load)                  count <= load_val;
        else if (tick && count != '0)   count <= at_one ? mod_val : count - 1'b1;
    end
endmodule

// File: rtl/pit_irq_flag.sv
// Module: sticky interrupt request flag. Set has priority over acknowledge.
module pit_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic flag
);
    // Holds the request until acknowledged; a new set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (ack)  flag <= 1'b0;
    end
endmodule

// File: rtl/periodic_irq_timer.sv
// Module: top of the periodic interrupt timer. The reference tick runs through
// the front divider and the optional prescaler into the modulus down-counter,
// whose expiry sets the request flag. Any register write clears both
// dividers and reloads the counter. Assumes ref_tick is a one-cycle enable.
module periodic_irq_timer
    import pit_pkg::*;
#(
    parameter int MOD_W     = 8,
    parameter int FRONT_DIV = PIT_FRONT_DIV,
    parameter int PRESCALE  = PIT_PRESCALE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             strap_in,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [MOD_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [MOD_W-1:0] rd_data,
    input  logic             irq_ack,
    output logic             irq_req
);
    logic [MOD_W-1:0] mod_q;
    logic [MOD_W-1:0] cnt_q;
    logic [MOD_W-1:0] load_val;
    logic             pre_sel_q;
    logic             mod_wr;
    logic             ctl_wr;
    logic             chain_clr;
    logic             front_tick;
    logic             scaled_tick;
    logic             pre_tick;
    logic             expire_w;

    pit_regs #(.MOD_W(MOD_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .mod_q(mod_q), .pre_sel_q(pre_sel_q),
        .mod_wr(mod_wr), .ctl_wr(ctl_wr)
    );

    assign chain_clr = mod_wr || ctl_wr;

    pit_tick_div #(.DIV(FRONT_DIV)) front_i (
        .clk(clk), .rst_n(rst_n), .clr(chain_clr),
        .in_tick(ref_tick), .out_tick(front_tick)
    );

    pit_tick_div #(.DIV(PRESCALE)) pres_i (
        .clk(clk), .rst_n(rst_n), .clr(chain_clr || !pre_sel_q),
        .in_tick(front_tick), .out_tick(scaled_tick)
    );

    // Prescaler bypass select.
    always_comb begin
        pre_tick = pre_sel_q ? scaled_tick : front_tick;
    end

    // Reload value: the incoming modulus on a modulus write, else the current one.
    always_comb begin
        load_val = mod_wr ? wr_data : mod_q;
    end

    pit_down_counter #(.MOD_W(MOD_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(chain_clr),
        .load_val(load_val), .mod_val(mod_q), .tick(pre_tick),
        .expire(expire_w), .count(cnt_q)
    );

    pit_irq_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set(expire_w),
        .ack(irq_ack), .flag(irq_req)
    );
endmodule

// File: rtl/pit_checker.sv
// Module: assertion checker bound to the timer top.
module pit_checker #(
    parameter int MOD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack,
    input logic             irq_req,
    input logic             expire,
    input logic             pre_tick,
    input logic             mod_wr,
    input logic [MOD_W-1:0] wr_data,
    input logic [MOD_W-1:0] mod_q,
    input logic [MOD_W-1:0] cnt_q
);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> irq_req);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !expire) |=> !irq_req);

    a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_req);

    a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(mod_q) != '0));

    a_r10_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
        mod_wr |=> (cnt_q == $past(wr_data)));

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mod_q);

    a_r4_expire_gated: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> pre_tick);
endmodule

bind periodic_irq_timer pit_checker #(.MOD_W(MOD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_req(irq_req),
    .expire(expire_w), .pre_tick(pre_tick), .mod_wr(mod_wr),
    .wr_data(wr_data), .mod_q(mod_q), .cnt_q(cnt_q)
);

// File: tb/periodic_irq_timer_tb.sv
module periodic_irq_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       strap_in = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    periodic_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .strap_in(strap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        strap_in = strap; rst_n = 1'b0; ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        strap_in = ~strap;
    endtask

    task automatic reg_wr(logic a, logic [7:0] d);
        @(negedge clk);
        ref_tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic reg_rd(logic a, output int v);
        @(negedge clk);
        rd_addr = a; #1;
        v = int'(rd_data);
    endtask

    task automatic run_ticks(int n, int gap);
        int c = 0;
        int ph = 0;
        while (c < n) begin
            @(negedge clk);
            ref_tick = (ph == 0);
            @(posedge clk);
            if (ph == 0) c++;
            ph = (ph + 1) % gap;
        end
    endtask

    task automatic see_irq(string req, int exp);
        @(negedge clk);
        ref_tick = 1'b0;
        chk(req, int'(irq_req), exp);
    endtask

    task automatic ack();
        @(negedge clk);
        ref_tick = 1'b0; irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic period_pair(int m, int per, int gap);
        reg_wr(1'b0, 8'(m));
        run_ticks(per - 1, gap); see_irq("R4 before expiry", 0);
        run_ticks(1, gap);       see_irq("R4 at expiry", 1);
        ack();                   see_irq("R8 ack clears", 0);
        run_ticks(per - 1, gap); see_irq("R7 before reload expiry", 0);
        run_ticks(1, gap);       see_irq("R7 reload expiry", 1);
        ack();
    endtask

    initial begin
        int v;
        // R1, R2: reset state and strap capture
        do_reset(1'b1);
        reg_rd(1'b0, v); chk("R1 modulus reset", v, 0);
        chk("R1 irq reset", int'(irq_req), 0);
        reg_rd(1'b1, v); chk("R2 strap 1 -> select 0", v, 0);
        do_reset(1'b0);
        reg_rd(1'b1, v); chk("R2 strap 0 -> select 1", v, 1);
        // R3: register map
        reg_wr(1'b1, 8'hFE);
        reg_rd(1'b1, v); chk("R3 ctl bit0 only", v, 0);
        reg_wr(1'b0, 8'hA5);
        reg_rd(1'b0, v); chk("R3 modulus readback", v, 165);
        reg_rd(1'b1, v); chk("R3 ctl unaffected", v, 0);
        // R4, R7, R8: sweep of modulus, continuous ticks
        for (int m = 1; m <= 32; m++) period_pair(m, 4 * m, 1);
        period_pair(255, 4 * 255, 1);
        // R4: sparse ticks
        for (int m = 1; m <= 8; m++) period_pair(m, 4 * m, 3);
        // R9: expiry together with acknowledge
        reg_wr(1'b0, 8'd2);
        run_ticks(8, 1); see_irq("R9 first expiry", 1);
        run_ticks(7, 1);
        @(negedge clk); ref_tick = 1'b1; irq_ack = 1'b1;
        @(negedge clk); ref_tick = 1'b0; irq_ack = 1'b0;
        chk("R9 expiry beats ack", int'(irq_req), 1);
        ack(); see_irq("R8 ack after R9", 0);
        // R10: modulus rewrite restarts period
        reg_wr(1'b0, 8'd3);
        run_ticks(5, 1);
        reg_wr(1'b0, 8'd3);
        run_ticks(11, 1); see_irq("R10 restart before", 0);
        run_ticks(1, 1);  see_irq("R10 restart at", 1);
        ack();
        // R10: control write restarts period
        reg_wr(1'b0, 8'd2);
        run_ticks(3, 1);
        reg_wr(1'b1, 8'd0);
        run_ticks(7, 1); see_irq("R10 ctl restart before", 0);
        run_ticks(1, 1); see_irq("R10 ctl restart at", 1);
        ack();
        // R5: prescaler on
        reg_wr(1'b1, 8'd1);
        for (int m = 1; m <= 2; m++) begin
            reg_wr(1'b0, 8'(m));
            run_ticks(2048 * m - 1, 1); see_irq("R5 before expiry", 0);
            run_ticks(1, 1);            see_irq("R5 at expiry", 1);
            ack();
        end
        reg_wr(1'b1, 8'd0);
        // R6: zero modulus
        reg_wr(1'b0, 8'd0);
        run_ticks(5000, 1); see_irq("R6 zero modulus silent", 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule